// File: doc/BRIEF.md
# Sampling Converter Host Bus Controller

This block is the digital side of a sampling converter as a host sees it over an asynchronous parallel bus. A falling edge on the active-low sample request input starts a conversion. The ready output drops for the length of the conversion. A 13-bit result register is presented on the data bus while chip select and read are both low. The same bus carries writes of a signed offset, which is added to every raw converter code before the result is stored.

Two latency modes are chosen by a pair of mode inputs. In immediate mode the result register is loaded as the conversion ends. In delayed mode every result waits in a pending register and moves to the result register at the next sample request, so a read returns the previous sample. The converter core is reached through a start strobe, a capture strobe and a 12-bit raw code input. A parameter selects whether the end of conversion comes from the core's done input or from an internal cycle counter of configurable length.

Top module: `sar_host_port`

## Requirements
- R1: While rstN is low and after it rises, rdy is 1, overrunErr is 0, the result register and the pending register are 0, and the offset is 0. Taking rstN low during a conversion ends it at once and no result is stored.
- R2: In a valid mode, a falling edge on sampleReqN while rdy is 1 starts a conversion. rdy goes low within 4 clock cycles of the edge, and convStart pulses for exactly one cycle.
- R3: With the internal counter as the end-of-conversion source, rdy stays low for exactly CONV_CYCLES clock cycles and then returns to 1.
- R4: In immediate mode (modeImm=1, modeDly=0), the new result is in the result register by the time rdy returns to 1.
- R5: In delayed mode (modeImm=0, modeDly=1), the result register keeps its old value through the conversion. At the next sample request it is loaded with the result of the conversion before that one.
- R6: With modeImm and modeDly equal (both 0 or both 1), falling edges on sampleReqN start nothing: rdy stays 1 and convStart does not pulse.
- R7: The stored result is the raw 12-bit code plus the signed offset. It is clamped to 0 or 4095 when out of range, and bit 12 is 1 only when clamping occurred.
- R8: dataOe is 1 exactly when csN and rdN are both 0. dataOut always shows the result register.
- R9: A falling edge on wrStb while csN is low writes dataIn[9:0] to the offset as a two's complement value, and dataIn[12:10] is ignored. A wrStb falling edge while csN is high changes nothing.
- R10: An offset write that arrives during a conversion takes effect only after that conversion ends. The conversion in flight uses the old offset.
- R11: A falling edge on sampleReqN while rdy is 0 does not start or restart a conversion, and it sets overrunErr, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleReqN | input | 1 | Sample request; a falling edge starts a conversion |
| csN | input | 1 | Active-low chip select |
| rdN | input | 1 | Active-low read |
| wrStb | input | 1 | Write pulse; the offset is latched on its falling edge |
| modeImm | input | 1 | Mode select bit for immediate update |
| modeDly | input | 1 | Mode select bit for one-sample-delayed update |
| dataIn | input | 13 | Data bus as driven by the host |
| dataOut | output | 13 | Result register toward the data bus pads |
| dataOe | output | 1 | Output enable for the data bus pads |
| rdy | output | 1 | 1 when idle, 0 during a conversion |
| overrunErr | output | 1 | Sticky flag for a sample request during a conversion |
| coreDone | input | 1 | End-of-conversion pulse from the converter core |
| coreCode | input | 12 | Raw converter code |
| convStart | output | 1 | One-cycle start strobe toward the core |
| resultCapture | output | 1 | One-cycle strobe marking the capture of coreCode |

## Verification
The assertions assume that sampleReqN, csN and wrStb stay at each level for at least two clock cycles, so that the three-stage synchronizers see every edge. They also assume that dataIn is stable for three cycles after a wrStb falling edge, and that coreCode is stable while a conversion runs. The stimulus holds every pin change for four cycles. It sets coreCode and the mode inputs only while rdy is 1, and it holds the write word for the full write pulse plus four cycles. Random offsets stay inside the signed 10-bit range, and random upper bus bits test that they are ignored.

// File: rtl/sar_host_pkg.sv
package sar_host_pkg;

  typedef struct packed {
    logic start;     // conversion begins
    logic promote;   // pending result -> result register (delayed mode)
    logic capture;   // conversion ends, raw code is taken
    logic capImm;    // capture also loads result register (immediate mode)
    logic wrNow;     // offset write applied at once
    logic wrHold;    // offset write parked until conversion end
    logic wrCommit;  // parked offset applied
  } strobe_t;

endpackage

// File: rtl/sar_host_ctrl.sv
module sar_host_ctrl
  import sar_host_pkg::*;
#(
  parameter int CONV_CYCLES   = 8,
  parameter bit USE_CORE_DONE = 1'b0
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sampleReqN,
  input  logic    csN,
  input  logic    wrStb,
  input  logic    modeImm,
  input  logic    modeDly,
  input  logic    coreDone,
  output strobe_t strb,
  output logic    rdy,
  output logic    overrunErr
);
  localparam int CntW = $clog2(CONV_CYCLES + 1);

  logic [2:0] reqSh;
  logic [2:0] wrSh;
  logic [1:0] csSh;
  logic       reqFall, wrFall, wrReq, modeOk, startNow, doneNow;
  logic       immSel, holdWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqSh <= 3'b111;
      wrSh  <= 3'b000;
      csSh  <= 2'b11;
    end else begin
      reqSh <= {reqSh[1:0], sampleReqN};
      wrSh  <= {wrSh[1:0], wrStb};
      csSh  <= {csSh[0], csN};
    end
  end

  assign reqFall  = reqSh[2] & ~reqSh[1];
  assign wrFall   = wrSh[2] & ~wrSh[1];
  assign wrReq    = wrFall & ~csSh[1];
  assign modeOk   = modeImm ^ modeDly;
  assign startNow = reqFall & rdy & modeOk;

  generate
    if (USE_CORE_DONE) begin : g_coreDone
      assign doneNow = coreDone & ~rdy;
    end else begin : g_countDone
      logic [CntW-1:0] cnt;
      logic            unusedDone;
      assign unusedDone = coreDone;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          cnt <= '0;
        else if (startNow)  cnt <= '0;
        else if (!rdy)      cnt <= cnt + 1'b1;
      end
      assign doneNow = ~rdy & (cnt == CntW'(CONV_CYCLES - 1));

      // R3
      conv_len_chk: assert property (@(posedge clk) disable iff (!rstN)
        !rdy |-> (cnt < CntW'(CONV_CYCLES)));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdy        <= 1'b1;
      immSel     <= 1'b0;
      overrunErr <= 1'b0;
      holdWr     <= 1'b0;
    end else begin
      if (startNow) begin
        rdy    <= 1'b0;
        immSel <= modeImm;
      end else if (doneNow) begin
        rdy <= 1'b1;
      end
      if (reqFall && !rdy) overrunErr <= 1'b1;
      if (wrReq && !rdy)        holdWr <= 1'b1;
      else if (holdWr && rdy)   holdWr <= 1'b0;
    end
  end

  always_comb begin
    strb          = '0;
    strb.start    = startNow;
    strb.promote  = startNow & ~modeImm;
    strb.capture  = doneNow;
    strb.capImm   = doneNow & immSel;
    strb.wrNow    = wrReq & rdy;
    strb.wrHold   = wrReq & ~rdy;
    strb.wrCommit = holdWr & rdy;
  end

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqFall && rdy && modeOk) |=> !rdy);
  // R6
  bad_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdy && !modeOk) |=> rdy);
  // R11
  overrun_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqFall && !rdy) |=> overrunErr);
  // R11
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrunErr |=> overrunErr);
  // R10
  offset_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrNow || strb.wrCommit) |-> !strb.capture);

endmodule

// File: rtl/sar_host_dp.sv
module sar_host_dp
  import sar_host_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     strb,
  input  logic [12:0] dataIn,
  input  logic [11:0] coreCode,
  output logic [12:0] dataOut
);
  logic [9:0]         offReg, holdWord;
  logic [12:0]        pendReg, outReg, result;
  logic signed [13:0] sum;
  logic [2:0]         unusedHigh;

  assign unusedHigh = dataIn[12:10];
  assign sum = $signed({2'b00, coreCode}) + $signed({{4{offReg[9]}}, offReg});

  always_comb begin
    if (sum < 0)                  result = {1'b1, 12'h000};
    else if (sum > 14'sd4095)     result = {1'b1, 12'hFFF};
    else                          result = {1'b0, sum[11:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offReg   <= '0;
      holdWord <= '0;
      pendReg  <= '0;
      outReg   <= '0;
    end else begin
      if (strb.wrNow)         offReg <= dataIn[9:0];
      else if (strb.wrCommit) offReg <= holdWord;
      if (strb.wrHold)        holdWord <= dataIn[9:0];
      if (strb.capture)       pendReg <= result;
      if (strb.capImm)        outReg <= result;
      else if (strb.promote)  outReg <= pendReg;
    end
  end

  assign dataOut = outReg;

  // R7
  sat_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    outReg[12] |-> (outReg[11:0] == 12'h000 || outReg[11:0] == 12'hFFF));
  // R5
  dly_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.capImm && !strb.promote) |=> $stable(outReg));

endmodule

// File: rtl/sar_host_port.sv
module sar_host_port
  import sar_host_pkg::*;
#(
  parameter int CONV_CYCLES   = 8,
  parameter bit USE_CORE_DONE = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleReqN,
  input  logic        csN,
  input  logic        rdN,
  input  logic        wrStb,
  input  logic        modeImm,
  input  logic        modeDly,
  input  logic [12:0] dataIn,
  output logic [12:0] dataOut,
  output logic        dataOe,
  output logic        rdy,
  output logic        overrunErr,
  input  logic        coreDone,
  input  logic [11:0] coreCode,
  output logic        convStart,
  output logic        resultCapture
);
  strobe_t strb;

  sar_host_ctrl #(.CONV_CYCLES(CONV_CYCLES), .USE_CORE_DONE(USE_CORE_DONE)) i_ctrl (
    .clk(clk), .rstN(rstN), .sampleReqN(sampleReqN), .csN(csN), .wrStb(wrStb),
    .modeImm(modeImm), .modeDly(modeDly), .coreDone(coreDone),
    .strb(strb), .rdy(rdy), .overrunErr(overrunErr)
  );

  sar_host_dp i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .dataIn(dataIn),
    .coreCode(coreCode), .dataOut(dataOut)
  );

  assign dataOe        = ~csN & ~rdN;
  assign convStart     = strb.start;
  assign resultCapture = strb.capture;

  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

endmodule

// File: tb/test_sar_host_port.sv
module test_sar_host_port;
  localparam int CONV = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleReqN = 1'b1, csN = 1'b1, rdN = 1'b1, wrStb = 1'b0;
  logic        modeImm = 1'b1, modeDly = 1'b0;
  logic [12:0] dataIn = '0;
  logic [12:0] dataOut;
  logic        dataOe, rdy, overrunErr, convStart, resultCapture;
  logic [11:0] coreCode = '0;

  int checks = 0, failures = 0, startCount = 0;
  int mOut = 0, mPend = 0, mOff = 0;

  always #10 clk = ~clk;

  sar_host_port #(.CONV_CYCLES(CONV)) i_sar_host_port (
    .clk(clk), .rstN(rstN), .sampleReqN(sampleReqN), .csN(csN), .rdN(rdN),
    .wrStb(wrStb), .modeImm(modeImm), .modeDly(modeDly), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe), .rdy(rdy), .overrunErr(overrunErr),
    .coreDone(1'b0), .coreCode(coreCode), .convStart(convStart),
    .resultCapture(resultCapture)
  );

  always @(posedge clk) if (rstN && convStart) startCount++;

  function automatic int satRes(input int code, input int off);
    int s = code + off;
    if (s < 0)    return 4096;
    if (s > 4095) return 4096 + 4095;
    return s;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic readBus(output int val, output int oe);
    @(negedge clk);
    csN = 1'b0; rdN = 1'b0;
    #1;
    val = dataOut; oe = dataOe;
    @(negedge clk);
    csN = 1'b1; rdN = 1'b1;
  endtask

  task automatic pulseReq();
    @(negedge clk);
    sampleReqN = 1'b0;
    repeat (4) @(negedge clk);
    sampleReqN = 1'b1;
    @(negedge clk);
  endtask

  task automatic writeBus(input logic [12:0] w, input logic useCs);
    @(negedge clk);
    csN = ~useCs; dataIn = w; wrStb = 1'b1;
    repeat (4) @(negedge clk);
    wrStb = 1'b0;
    repeat (4) @(negedge clk);
    csN = 1'b1;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (!rdy && n < 200) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  task automatic setMode(input logic imm);
    @(negedge clk);
    modeImm = imm; modeDly = ~imm;
  endtask

  // full conversion with model update; returns after completion
  task automatic convert(input logic imm, input int code, input string req);
    int v, oe;
    setMode(imm);
    coreCode = code[11:0];
    pulseReq();
    chk({req, " busy"}, rdy, 0);
    if (!imm) mOut = mPend;
    waitIdle();
    mPend = satRes(code, mOff);
    if (imm) mOut = mPend;
    readBus(v, oe);
    chk(req, v, mOut);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int v, oe, lowCnt, s0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state while held
    chk("R1 rdy in reset", rdy, 1);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 rdy", rdy, 1);
    chk("R1 overrunErr", overrunErr, 0);
    readBus(v, oe);
    chk("R1 result", v, 0);

    // R8 output enable decode
    csN = 1'b0; rdN = 1'b1; #1; chk("R8 oe cs only", dataOe, 0);
    csN = 1'b1; rdN = 1'b0; #1; chk("R8 oe rd only", dataOe, 0);
    csN = 1'b0; rdN = 1'b0; #1; chk("R8 oe both", dataOe, 1);
    csN = 1'b1; rdN = 1'b1; #1; chk("R8 oe none", dataOe, 0);

    // R3 exact busy length, R2 single start pulse
    setMode(1'b1);
    coreCode = 12'd100;
    s0 = startCount;
    lowCnt = 0;
    sampleReqN = 1'b0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (k == 3) sampleReqN = 1'b1;
      if (!rdy) lowCnt++;
      else if (lowCnt > 0) break;
    end
    chk("R3 busy cycles", lowCnt, CONV);
    chk("R2 one convStart", startCount - s0, 1);
    mPend = satRes(100, 0); mOut = mPend;
    readBus(v, oe);
    chk("R4 immediate result", v, mOut);

    // R6 invalid modes ignore requests
    for (int m = 0; m < 2; m++) begin
      @(negedge clk);
      modeImm = m[0]; modeDly = m[0];
      s0 = startCount;
      pulseReq();
      repeat (4) @(negedge clk);
      chk("R6 rdy stays high", rdy, 1);
      chk("R6 no convStart", startCount - s0, 0);
    end

    // R9 write ignored without chip select
    writeBus(13'd50, 1'b0);
    convert(1'b1, 1000, "R9 no-cs write ignored");
    // R9 write with garbage upper bits, negative offset
    writeBus({3'b101, 10'h380}, 1'b1);   // -128
    mOff = -128;
    convert(1'b1, 1000, "R9 offset applied");
    // R7 saturation low and high
    convert(1'b1, 5, "R7 clamp low");
    chk("R7 flag low", mOut, 4096);
    writeBus(13'd300, 1'b1);
    mOff = 300;
    convert(1'b1, 4000, "R7 clamp high");
    convert(1'b1, 3795, "R7 top edge no clamp");

    // R5 delayed mode: result one sample late
    convert(1'b0, 200, "R5 delayed first");
    convert(1'b0, 700, "R5 delayed second");

    // R10 write during conversion is deferred
    setMode(1'b1);
    coreCode = 12'd1000;
    pulseReq();
    writeBus(13'd0, 1'b1);
    chk("R10 still busy during write", rdy, 0);
    waitIdle();
    mPend = satRes(1000, mOff); mOut = mPend;
    readBus(v, oe);
    chk("R10 old offset used", v, mOut);
    mOff = 0;
    convert(1'b1, 1000, "R10 new offset after");

    // R11 overrun
    setMode(1'b1);
    coreCode = 12'd42;
    s0 = startCount;
    pulseReq();
    chk("R11 no flag yet", overrunErr, 0);
    pulseReq();
    repeat (3) @(negedge clk);
    chk("R11 flag set", overrunErr, 1);
    waitIdle();
    chk("R11 single start", startCount - s0, 1);
    mPend = satRes(42, mOff); mOut = mPend;
    readBus(v, oe);
    chk("R11 result intact", v, mOut);
    convert(1'b1, 77, "R11 later conversion");
    chk("R11 flag sticky", overrunErr, 1);

    // random mix
    for (int i = 0; i < 30; i++) begin
      if ($urandom_range(0, 3) == 0) begin
        int o = $urandom_range(0, 654) - 327;
        logic [12:0] w;
        w = {3'($urandom_range(0, 7)), 10'(o)};
        writeBus(w, 1'b1);
        mOff = o;
      end
      convert(1'($urandom_range(0, 1)), $urandom_range(0, 4095), "R4/R5/R7 random");
    end

    // R1 reset aborts conversion
    setMode(1'b1);
    coreCode = 12'd900;
    pulseReq();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 abort rdy", rdy, 1);
    chk("R1 abort flag clear", overrunErr, 0);
    repeat (CONV + 4) @(negedge clk);
    readBus(v, oe);
    chk("R1 abort no result", v, 0);
    mOut = 0; mPend = 0; mOff = 0;
    convert(1'b1, 123, "R1 offset cleared");

    summary();
    $finish;
  end
endmodule